// File: doc/BRIEF.md
# Interrupt entry sequencer

This block carries out the memory side of taking an interrupt in a processor that runs either in a 16-bit paged addressing mode, where a base-page byte supplies address bits 23:16, or in a 24-bit linear mode. A one-cycle `start` pulse latches the trigger kind: a non-maskable request or a maskable request in mode 0, 1 or 2. It also latches the current mode bit, the mixed-mode control bit, the base page, the vector register, the program counter and both stack pointers. The block then walks through a fixed series of byte transfers on a simple request/acknowledge port. The series is: interrupt-acknowledge bytes where the mode needs them, stack writes of the return address and, when mixed mode is on, a marker byte, and for mode 2 a little-endian vector fetch.

When the last transfer completes, the block raises `done` for one cycle. At that point it presents the handler program counter, the handler mode bit and the updated stack pointers. These values are held until the next sequence ends. The surrounding core issues `start`, waits for `done`, and loads the results.

Top module: `int_entry_seq`

## Requirements
- R1: After reset, `done`, `mem_req`, `adl_out`, `pc_out`, `sps_out` and `spl_out` are all 0.
- R2: The return address is pushed most significant byte first, each write one address below the previous one, so the low byte lands at the lowest address. It is 2 bytes (PC[15:0]) when the latched mode bit is 0 and 3 bytes (PC[23:0]) when it is 1.
- R3: When the mode bit and mixed bit are both 0, stack writes go to {base page, short pointer − k} and `sps_out` drops by the number of pushed bytes, with `spl_out` unchanged. In every other case writes go to long pointer − k, `spl_out` drops by the push count and `sps_out` is unchanged.
- R4: When the mixed bit is 1, one marker byte is written after the return address at the next lower address. It is 02h/03h for non-maskable, mode 0 and mode 1 entries, and 00h/01h for mode 2 entries, the low bit being the interrupted mode bit.
- R5: On a completed entry, `adl_out` is 1 when the mixed bit or the mode bit is 1, and 0 otherwise.
- R6: A non-maskable entry targets 0066h and a mode 1 entry targets 0038h, neither with an acknowledge cycle. In pure 16-bit mode `pc_out` = {base page, target}; otherwise it is the target zero-extended to 24 bits.
- R7: Mode 0 performs one acknowledge cycle. A restart opcode (bit pattern 11xxx111) sends the handler to the opcode AND 38h, zero-extended (or paged as in R6).
- R8: In mode 0, the opcode CDh is followed by further acknowledge cycles delivering an address low byte first: 2 bytes in pure 16-bit mode (paged as in R6), 3 bytes otherwise. The pushes follow these cycles.
- R9: In mode 0, any other acknowledge byte ends the sequence with no write. `pc_out`, `adl_out`, `sps_out` and `spl_out` then equal the latched inputs.
- R10: Mode 2 (mode code 2 or 3) reads one acknowledge byte D and forces D[0] to 0. After the pushes it reads the vector little-endian from consecutive addresses: 2 bytes from {base page, I[7:0], D} in pure 16-bit mode, else 3 bytes from {I[15:0], D}. The result becomes the target.
- R11: `mem_req` stays high with stable `mem_op`, `mem_addr` and `mem_wdata` until the cycle `mem_ack` is seen. The `mem_op` codes are 1 for a write, 2 for a read and 3 for an interrupt acknowledge.
- R12: `done` is a single-cycle pulse with no request active. `start` is ignored while a sequence is running, including the `done` cycle. Context inputs are sampled only on the accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an entry sequence (taken only when idle) |
| is_nmi | input | 1 | 1: non-maskable entry, mode code ignored |
| int_mode | input | 2 | Maskable mode: 0, 1, 2 (3 acts as 2) |
| adl_bit | input | 1 | Current addressing mode bit (1 = 24-bit) |
| mixed_bit | input | 1 | Mixed-mode control bit |
| mbase | input | 8 | Base page byte for 16-bit mode |
| ivec | input | 16 | Vector register |
| pc_in | input | 24 | Program counter at entry |
| sps_in | input | 16 | Short stack pointer |
| spl_in | input | 24 | Long stack pointer |
| mem_req | output | 1 | Transfer request |
| mem_op | output | 2 | 1 write, 2 read, 3 acknowledge |
| mem_addr | output | 24 | Transfer address (0 for acknowledge) |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Transfer completes this cycle |
| mem_rdata | input | 8 | Read or acknowledge byte, valid with `mem_ack` |
| done | output | 1 | Sequence finished, results valid |
| pc_out | output | 24 | Handler program counter |
| adl_out | output | 1 | Handler mode bit |
| sps_out | output | 16 | Updated short stack pointer |
| spl_out | output | 24 | Updated long stack pointer |

## Verification
Two events can land in the same cycle: the `done` pulse that closes one sequence and a fresh `start` pulse. A second coincidence is a `start` pulse and a sequence still mid-transfer. The bench raises `start` exactly in the cycle it first sees `done`, and in another case two cycles into a busy sequence, each time with different context on the inputs. Both are judged at the ports. The scoreboard must see no transfer and no further `done` beyond what the first sequence predicts, and `mem_req` must stay low afterwards.

// File: rtl/ies_pkg.sv
package ies_pkg;
  localparam int ADDR_W  = 24;
  localparam int SHORT_W = 16;
  localparam int BYTE_W  = 8;
  localparam int PAGE_W  = ADDR_W - SHORT_W;
  localparam int WORD_BYTES = ADDR_W / BYTE_W;
  localparam int IDX_W   = 3;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_IACK  = 2'd3
  } mem_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_IACK, ST_PUSH, ST_VREAD, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    K_NMI = 2'd0,
    K_IM1 = 2'd1,
    K_ACK = 2'd2,
    K_VEC = 2'd3
  } entry_kind_e;

  typedef struct packed {
    entry_kind_e         kind;
    logic                adl;
    logic                mix;
    logic [PAGE_W-1:0]   mbase;
    logic [SHORT_W-1:0]  ivec;
    logic [ADDR_W-1:0]   pc;
    logic [SHORT_W-1:0]  sps;
    logic [ADDR_W-1:0]   spl;
  } entry_ctx_t;

  function automatic entry_kind_e classify(input logic nmi, input logic [1:0] im);
    if (nmi)        return K_NMI;
    else if (im[1]) return K_VEC;
    else if (im[0]) return K_IM1;
    else            return K_ACK;
  endfunction

  function automatic logic is_restart(input logic [BYTE_W-1:0] b);
    return (b & 8'hC7) == 8'hC7;
  endfunction

  function automatic logic [BYTE_W-1:0] marker_byte(input logic vec, input logic adl);
    return {6'd0, ~vec, adl};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [ADDR_W-1:0] v,
                                                  input logic [IDX_W-1:0] sel);
    case (sel)
      3'd0:    return v[7:0];
      3'd1:    return v[15:8];
      default: return v[23:16];
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] stack_slot(input logic wide,
                                                   input logic [PAGE_W-1:0] page,
                                                   input logic [SHORT_W-1:0] sp_s,
                                                   input logic [ADDR_W-1:0] sp_l,
                                                   input logic [IDX_W-1:0] k);
    if (wide) return sp_l - {{(ADDR_W-IDX_W){1'b0}}, k};
    else      return {page, sp_s - {{(SHORT_W-IDX_W){1'b0}}, k}};
  endfunction

  function automatic logic [ADDR_W-1:0] entry_target(input entry_kind_e kind,
                                                     input logic wide,
                                                     input logic [PAGE_W-1:0] page,
                                                     input logic [BYTE_W-1:0] dbyte,
                                                     input logic [ADDR_W-1:0] word,
                                                     input logic [SHORT_W-1:0] nmi_t,
                                                     input logic [SHORT_W-1:0] im1_t,
                                                     input logic [BYTE_W-1:0] call_op);
    logic [ADDR_W-1:0] t;
    case (kind)
      K_NMI:   t = {{PAGE_W{1'b0}}, nmi_t};
      K_IM1:   t = {{PAGE_W{1'b0}}, im1_t};
      K_VEC:   t = word;
      default: t = (dbyte == call_op) ? word : {{SHORT_W{1'b0}}, dbyte & 8'h38};
    endcase
    return wide ? t : {page, t[SHORT_W-1:0]};
  endfunction
endpackage

// File: rtl/ies_plan.sv
module ies_plan
  import ies_pkg::*;
(
  input  entry_kind_e        kind,
  input  logic               adl,
  input  logic               mix,
  output logic               wide,
  output logic               vec_mode,
  output logic [IDX_W-1:0]   n_ret,
  output logic [IDX_W-1:0]   n_push,
  output logic [IDX_W-1:0]   n_word,
  output logic [BYTE_W-1:0]  marker
);
  localparam logic [IDX_W-1:0] LONG_BYTES  = IDX_W'(WORD_BYTES);
  localparam logic [IDX_W-1:0] SHORT_BYTES = IDX_W'(SHORT_W / BYTE_W);

  always_comb begin
    wide     = adl | mix;
    vec_mode = (kind == K_VEC);
    n_ret    = adl ? LONG_BYTES : SHORT_BYTES;
    n_push   = n_ret + {{(IDX_W-1){1'b0}}, mix};
    n_word   = wide ? LONG_BYTES : SHORT_BYTES;
    marker   = marker_byte(vec_mode, adl);
  end
endmodule

// File: rtl/ies_push_gen.sv
module ies_push_gen
  import ies_pkg::*;
(
  input  logic               wide,
  input  logic [PAGE_W-1:0]  mbase,
  input  logic [SHORT_W-1:0] sps,
  input  logic [ADDR_W-1:0]  spl,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [IDX_W-1:0]   n_ret,
  input  logic [BYTE_W-1:0]  marker,
  input  logic [IDX_W-1:0]   idx,
  output logic [ADDR_W-1:0]  addr,
  output logic [BYTE_W-1:0]  data
);
  logic [IDX_W-1:0] slot_k;
  logic [IDX_W-1:0] byte_sel;

  always_comb begin
    slot_k   = idx + 3'd1;
    byte_sel = n_ret - 3'd1 - idx;
    addr     = stack_slot(wide, mbase, sps, spl, slot_k);
    data     = (idx < n_ret) ? pick_byte(pc, byte_sel) : marker;
  end
endmodule

// File: rtl/ies_vec_gen.sv
module ies_vec_gen
  import ies_pkg::*;
(
  input  logic               wide,
  input  logic [PAGE_W-1:0]  mbase,
  input  logic [SHORT_W-1:0] ivec,
  input  logic [BYTE_W-1:1]  dbyte_hi,
  input  logic [IDX_W-1:0]   idx,
  output logic [ADDR_W-1:0]  addr
);
  logic [ADDR_W-1:0] base;

  always_comb begin
    if (wide) base = {ivec, dbyte_hi, 1'b0};
    else      base = {mbase, ivec[PAGE_W-1:0], dbyte_hi, 1'b0};
    addr = base + {{(ADDR_W-IDX_W){1'b0}}, idx};
  end
endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
  import ies_pkg::*;
#(
  parameter logic [15:0] NMI_TARGET = 16'h0066,
  parameter logic [15:0] IM1_TARGET = 16'h0038,
  parameter logic [7:0]  CALL_OP    = 8'hCD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_nmi,
  input  logic [1:0]  int_mode,
  input  logic        adl_bit,
  input  logic        mixed_bit,
  input  logic [7:0]  mbase,
  input  logic [15:0] ivec,
  input  logic [23:0] pc_in,
  input  logic [15:0] sps_in,
  input  logic [23:0] spl_in,
  output logic        mem_req,
  output logic [1:0]  mem_op,
  output logic [23:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ack,
  input  logic [7:0]  mem_rdata,
  output logic        done,
  output logic [23:0] pc_out,
  output logic        adl_out,
  output logic [15:0] sps_out,
  output logic [23:0] spl_out
);
  seq_state_e        state;
  entry_ctx_t        ctx;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] dbyte;
  logic [ADDR_W-1:0] cap_word;
  logic [ADDR_W-1:0] ins_word;
  logic [ADDR_W-1:0] final_word;
  logic [IDX_W-1:0]  ins_sel;

  logic              wide, vec_mode;
  logic [IDX_W-1:0]  n_ret, n_push, n_word;
  logic [BYTE_W-1:0] marker;
  logic [ADDR_W-1:0] push_addr, vec_addr;
  logic [BYTE_W-1:0] push_data;

  // named events for the checker
  logic              xfer_fire;
  logic              seq_accept;
  logic              last_push, last_vec, fin_noop;
  entry_kind_e       start_kind;

  logic [ADDR_W-1:0]  fin_pc;
  logic               fin_adl;
  logic [SHORT_W-1:0] fin_sps;
  logic [ADDR_W-1:0]  fin_spl;

  ies_plan u_plan (
    .kind(ctx.kind), .adl(ctx.adl), .mix(ctx.mix),
    .wide(wide), .vec_mode(vec_mode), .n_ret(n_ret), .n_push(n_push),
    .n_word(n_word), .marker(marker)
  );

  ies_push_gen u_push (
    .wide(wide), .mbase(ctx.mbase), .sps(ctx.sps), .spl(ctx.spl), .pc(ctx.pc),
    .n_ret(n_ret), .marker(marker), .idx(idx), .addr(push_addr), .data(push_data)
  );

  ies_vec_gen u_vec (
    .wide(wide), .mbase(ctx.mbase), .ivec(ctx.ivec), .dbyte_hi(dbyte[BYTE_W-1:1]),
    .idx(idx), .addr(vec_addr)
  );

  assign xfer_fire  = mem_req & mem_ack;
  assign seq_accept = start && (state == ST_IDLE);
  assign start_kind = classify(is_nmi, int_mode);
  assign last_push  = (idx == n_push - 3'd1);
  assign last_vec   = (idx == n_word - 3'd1);
  assign fin_noop   = (state == ST_IACK);
  assign ins_sel    = (state == ST_IACK) ? idx - 3'd1 : idx;

  generate
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_ins
      assign ins_word[b*BYTE_W +: BYTE_W] =
        (ins_sel == IDX_W'(b)) ? mem_rdata : cap_word[b*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_comb begin
    final_word = (state == ST_VREAD) ? ins_word : cap_word;
    fin_pc  = fin_noop ? ctx.pc :
              entry_target(ctx.kind, wide, ctx.mbase, dbyte, final_word,
                           NMI_TARGET, IM1_TARGET, CALL_OP);
    fin_adl = fin_noop ? ctx.adl : wide;
    fin_sps = (fin_noop || wide)  ? ctx.sps : ctx.sps - {{(SHORT_W-IDX_W){1'b0}}, n_push};
    fin_spl = (fin_noop || !wide) ? ctx.spl : ctx.spl - {{(ADDR_W-IDX_W){1'b0}}, n_push};
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_op    = OP_IDLE;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_IACK:  begin mem_req = 1'b1; mem_op = OP_IACK; end
      ST_PUSH:  begin mem_req = 1'b1; mem_op = OP_WRITE;
                      mem_addr = push_addr; mem_wdata = push_data; end
      ST_VREAD: begin mem_req = 1'b1; mem_op = OP_READ; mem_addr = vec_addr; end
      default:  ;
    endcase
  end

  assign done = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ctx      <= '0;
      idx      <= '0;
      dbyte    <= '0;
      cap_word <= '0;
      pc_out   <= '0;
      adl_out  <= 1'b0;
      sps_out  <= '0;
      spl_out  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          ctx.kind  <= start_kind;
          ctx.adl   <= adl_bit;
          ctx.mix   <= mixed_bit;
          ctx.mbase <= mbase;
          ctx.ivec  <= ivec;
          ctx.pc    <= pc_in;
          ctx.sps   <= sps_in;
          ctx.spl   <= spl_in;
          idx       <= '0;
          dbyte     <= '0;
          cap_word  <= '0;
          state     <= (start_kind == K_ACK || start_kind == K_VEC) ? ST_IACK : ST_PUSH;
        end
        ST_IACK: if (xfer_fire) begin
          if (idx == '0) begin
            dbyte <= mem_rdata;
            if (ctx.kind == K_VEC || is_restart(mem_rdata)) state <= ST_PUSH;
            else if (mem_rdata == CALL_OP) idx <= 3'd1;
            else begin
              state   <= ST_DONE;
              pc_out  <= fin_pc;
              adl_out <= fin_adl;
              sps_out <= fin_sps;
              spl_out <= fin_spl;
            end
          end else begin
            cap_word <= ins_word;
            if (idx == n_word) begin
              state <= ST_PUSH;
              idx   <= '0;
            end else idx <= idx + 3'd1;
          end
        end
        ST_PUSH: if (xfer_fire) begin
          if (last_push) begin
            idx <= '0;
            if (vec_mode) state <= ST_VREAD;
            else begin
              state   <= ST_DONE;
              pc_out  <= fin_pc;
              adl_out <= fin_adl;
              sps_out <= fin_sps;
              spl_out <= fin_spl;
            end
          end else idx <= idx + 3'd1;
        end
        ST_VREAD: if (xfer_fire) begin
          cap_word <= ins_word;
          if (last_vec) begin
            state   <= ST_DONE;
            pc_out  <= fin_pc;
            adl_out <= fin_adl;
            sps_out <= fin_sps;
            spl_out <= fin_spl;
          end else idx <= idx + 3'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ies_checker.sv
module ies_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        seq_accept,
  input logic        adl_bit,
  input logic        mixed_bit,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [1:0]  mem_op,
  input logic [23:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic        done,
  input logic        adl_out
);
  logic        cap_adl, cap_mix;
  logic [2:0]  wr_cnt;
  logic [15:0] prev_low;
  logic        wr_fire;

  assign wr_fire = mem_req && mem_ack && (mem_op == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_adl  <= 1'b0;
      cap_mix  <= 1'b0;
      wr_cnt   <= '0;
      prev_low <= '0;
    end else if (seq_accept) begin
      cap_adl <= adl_bit;
      cap_mix <= mixed_bit;
      wr_cnt  <= '0;
    end else if (wr_fire) begin
      wr_cnt   <= wr_cnt + 3'd1;
      prev_low <= mem_addr[15:0];
    end
  end

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_op) && $stable(mem_addr) && $stable(mem_wdata)));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  p_push_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wr_cnt != 3'd0) |-> (wr_cnt == ((cap_adl ? 3'd3 : 3'd2) + {2'd0, cap_mix})));

  p_mixed_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wr_cnt != 3'd0 && cap_mix) |-> adl_out);

  p_push_descend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_cnt != 3'd0) |-> (mem_addr[15:0] == prev_low - 16'd1));
endmodule

bind int_entry_seq ies_checker u_ies_checker (
  .clk(clk), .rst_n(rst_n), .seq_accept(seq_accept), .adl_bit(adl_bit),
  .mixed_bit(mixed_bit), .mem_req(mem_req), .mem_ack(mem_ack), .mem_op(mem_op),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .adl_out(adl_out)
);

// File: tb/test_int_entry_seq.sv
module test_int_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, is_nmi, adl_bit, mixed_bit;
  logic [1:0]  int_mode;
  logic [7:0]  mbase;
  logic [15:0] ivec, sps_in;
  logic [23:0] pc_in, spl_in;
  logic        mem_req, mem_ack, done, adl_out;
  logic [1:0]  mem_op;
  logic [23:0] mem_addr, pc_out, spl_out;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] sps_out;

  always #10 clk = ~clk;

  int_entry_seq i_int_entry_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .is_nmi(is_nmi), .int_mode(int_mode),
    .adl_bit(adl_bit), .mixed_bit(mixed_bit), .mbase(mbase), .ivec(ivec),
    .pc_in(pc_in), .sps_in(sps_in), .spl_in(spl_in), .mem_req(mem_req),
    .mem_op(mem_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .pc_out(pc_out), .adl_out(adl_out),
    .sps_out(sps_out), .spl_out(spl_out)
  );

  typedef struct { logic [1:0] op; logic [23:0] addr; logic [7:0] data; } txn_t;
  typedef struct { logic [23:0] pc; logic adl; logic [15:0] sps; logic [23:0] spl; } fin_t;

  txn_t       exp_q[$];
  fin_t       fin_q[$];
  logic [7:0] iack_q[$];
  int         n_chk = 0;
  int         n_fail = 0;
  int         stall = 0;
  int         wait_cnt = 0;
  string      cur_req = "R1";
  bit         finished = 0;

  function automatic logic [7:0] memf(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor and responder: compare each transfer, then acknowledge it
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack   = 1'b0;
      mem_rdata = 8'h00;
      wait_cnt  = 0;
    end else begin
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wait_cnt < stall) wait_cnt++;
        else begin
          txn_t e;
          wait_cnt = 0;
          if (exp_q.size() == 0) begin
            check(0, cur_req, "unexpected transfer op", {62'd0, mem_op}, 64'd0);
            mem_rdata = 8'h00;
          end else begin
            e = exp_q.pop_front();
            if (e.op == 2'd1)
              check(mem_op == e.op && mem_addr == e.addr && mem_wdata == e.data, cur_req,
                    "write op/addr/data", {30'd0, mem_op, mem_addr, mem_wdata},
                    {30'd0, e.op, e.addr, e.data});
            else if (e.op == 2'd2)
              check(mem_op == e.op && mem_addr == e.addr, cur_req, "read op/addr",
                    {38'd0, mem_op, mem_addr}, {38'd0, e.op, e.addr});
            else
              check(mem_op == e.op, cur_req, "ack op", {62'd0, mem_op}, {62'd0, e.op});
            if (mem_op == 2'd3) mem_rdata = (iack_q.size() != 0) ? iack_q.pop_front() : 8'h00;
            else mem_rdata = memf(mem_addr);
          end
          mem_ack = 1'b1;
        end
      end
      if (done) begin
        if (fin_q.size() == 0)
          check(0, cur_req, "unexpected done", 64'd1, 64'd0);
        else begin
          fin_t f;
          f = fin_q.pop_front();
          check(pc_out == f.pc && adl_out == f.adl && sps_out == f.sps && spl_out == f.spl,
                cur_req, "pc/adl/sps/spl", {pc_out, adl_out, 7'd0, sps_out, spl_out[15:0]},
                {f.pc, f.adl, 7'd0, f.sps, f.spl[15:0]});
          check(exp_q.size() == 0, cur_req, "transfers left at done", exp_q.size(), 0);
        end
      end
    end
  end

  task automatic add_txn(input logic [1:0] op, input logic [23:0] a, input logic [7:0] d);
    txn_t t;
    t.op = op; t.addr = a; t.data = d;
    exp_q.push_back(t);
  endtask

  // driver: builds the expected series from the requirements, then runs it
  task automatic run_case(input string req, input bit nmi, input logic [1:0] im,
                          input bit adl, input bit mix, input logic [7:0] mb,
                          input logic [15:0] iv, input logic [23:0] pc,
                          input logic [15:0] sps, input logic [23:0] spl,
                          input logic [7:0] d0, input logic [23:0] imm,
                          input int stl, input bit poke_busy, input bit poke_done);
    bit          wide, do_ack, noop, vec;
    int          nret, nw, npush;
    logic [23:0] tgt, base, spn;
    fin_t        f;
    cur_req = req;
    stall   = stl;
    wide    = adl | mix;
    vec     = !nmi && im[1];
    do_ack  = !nmi && (im != 2'd1);
    nw      = wide ? 3 : 2;
    noop    = 0;
    tgt     = 24'h0;
    if (do_ack) begin add_txn(2'd3, 24'h0, 8'h00); iack_q.push_back(d0); end
    if (nmi) tgt = 24'h000066;
    else if (im == 2'd1) tgt = 24'h000038;
    else if (!vec) begin
      if ((d0 & 8'hC7) == 8'hC7) tgt = {16'h0, d0 & 8'h38};
      else if (d0 == 8'hCD) begin
        for (int k = 0; k < nw; k++) begin
          add_txn(2'd3, 24'h0, 8'h00);
          iack_q.push_back(imm[8*k +: 8]);
        end
        tgt = wide ? imm : {8'h0, imm[15:0]};
      end else noop = 1;
    end
    if (noop) begin
      f.pc = pc; f.adl = adl; f.sps = sps; f.spl = spl;
    end else begin
      nret  = adl ? 3 : 2;
      npush = nret + (mix ? 1 : 0);
      for (int j = 0; j < npush; j++) begin
        logic [23:0] a;
        logic [7:0]  d;
        a = wide ? spl - 24'(j + 1) : {mb, sps - 16'(j + 1)};
        d = (j < nret) ? 8'(pc >> (8 * (nret - 1 - j))) : (vec ? {7'd0, adl} : {6'd0, 1'b1, adl});
        add_txn(2'd1, a, d);
      end
      if (vec) begin
        base = wide ? {iv, d0 & 8'hFE} : {mb, iv[7:0], d0 & 8'hFE};
        tgt  = 24'h0;
        for (int j = 0; j < nw; j++) begin
          add_txn(2'd2, base + 24'(j), 8'h00);
          tgt[8*j +: 8] = memf(base + 24'(j));
        end
      end
      spn   = wide ? spl - 24'(npush) : {8'h0, sps - 16'(npush)};
      f.pc  = wide ? tgt : {mb, tgt[15:0]};
      f.adl = wide;
      f.sps = wide ? sps : spn[15:0];
      f.spl = wide ? spn : spl;
    end
    fin_q.push_back(f);

    @(negedge clk);
    is_nmi = nmi; int_mode = im; adl_bit = adl; mixed_bit = mix; mbase = mb;
    ivec = iv; pc_in = pc; sps_in = sps; spl_in = spl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    is_nmi = ~nmi; int_mode = ~im; adl_bit = ~adl; mixed_bit = ~mix; mbase = ~mb;
    ivec = ~iv; pc_in = ~pc; sps_in = ~sps; spl_in = ~spl;
    if (poke_busy) begin
      @(negedge clk);
      if (!done) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    begin
      int guard = 0;
      while (!done && guard < 200) begin @(negedge clk); guard++; end
      check(guard < 200, req, "done seen", guard, 0);
    end
    if (poke_done) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0 && fin_q.size() == 0 && !mem_req, req, "quiet after done",
          {exp_q.size(), fin_q.size()[30:0], mem_req}, 0);
    exp_q.delete();
    fin_q.delete();
    iack_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; is_nmi = 1'b0; int_mode = 2'd0; adl_bit = 1'b0;
    mixed_bit = 1'b0; mbase = 8'h0; ivec = 16'h0; pc_in = 24'h0; sps_in = 16'h0;
    spl_in = 24'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !mem_req && !adl_out && pc_out == 24'h0 && sps_out == 16'h0 && spl_out == 24'h0,
          "R1", "reset outputs", {done, mem_req, adl_out, pc_out}, 0);

    // req  nmi im adl mix mbase ivec pc sps spl d0 imm stall busy done
    run_case("R2 R3 R6", 1, 2'd0, 0, 0, 8'h40, 16'h0, 24'h123456, 16'h8000, 24'h300000, 8'h0, 24'h0, 0, 0, 0);
    run_case("R2 R3 R6", 1, 2'd0, 1, 0, 8'h40, 16'h0, 24'hABCDEF, 16'h8000, 24'h300000, 8'h0, 24'h0, 0, 0, 0);
    run_case("R4 R5 R6", 1, 2'd0, 0, 1, 8'h41, 16'h0, 24'h77AA55, 16'h9000, 24'h310000, 8'h0, 24'h0, 0, 0, 0);
    run_case("R4 R6 R11", 0, 2'd1, 1, 1, 8'h42, 16'h0, 24'h0F1E2D, 16'h9000, 24'h320010, 8'h0, 24'h0, 2, 0, 0);
    run_case("R6 R3", 0, 2'd1, 0, 0, 8'h43, 16'h0, 24'h001234, 16'h4000, 24'h330000, 8'h0, 24'h0, 0, 0, 0);
    run_case("R7 R12", 0, 2'd0, 0, 0, 8'h44, 16'h0, 24'h005678, 16'h5000, 24'h340000, 8'hD7, 24'h0, 1, 1, 0);
    run_case("R7", 0, 2'd0, 1, 0, 8'h45, 16'h0, 24'h345678, 16'h5000, 24'h350000, 8'hFF, 24'h0, 0, 0, 0);
    run_case("R8", 0, 2'd0, 0, 0, 8'h46, 16'h0, 24'h00A0B0, 16'h6000, 24'h360000, 8'hCD, 24'h001234, 0, 0, 0);
    run_case("R8 R4 R11", 0, 2'd0, 0, 1, 8'h47, 16'h0, 24'h00C0D0, 16'h6000, 24'h370000, 8'hCD, 24'h123456, 2, 0, 0);
    run_case("R9 R12", 0, 2'd0, 1, 1, 8'h48, 16'h0, 24'h111111, 16'h7000, 24'h380000, 8'h00, 24'h0, 0, 0, 1);
    run_case("R9", 0, 2'd0, 0, 0, 8'h49, 16'h0, 24'h002222, 16'h7000, 24'h390000, 8'hC6, 24'h0, 0, 0, 0);
    run_case("R10", 0, 2'd2, 0, 0, 8'h4A, 16'h1234, 24'h003333, 16'h7100, 24'h3A0000, 8'h21, 24'h0, 0, 0, 0);
    run_case("R10 R4", 0, 2'd2, 1, 1, 8'h4B, 16'h5678, 24'h444444, 16'h7200, 24'h3B0000, 8'h40, 24'h0, 1, 0, 0);
    run_case("R10 R4 R5", 0, 2'd3, 0, 1, 8'h4C, 16'h9A00, 24'h005555, 16'h7300, 24'h3C0000, 8'h13, 24'h0, 0, 0, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule